// File: doc/BRIEF.md
# Shared Multi-Thread Event Timer

This block is one event timer that every hardware thread of a core shares. A thread subscribes by setting its own bit in a subscriber mask. It then arms the timer by loading a terminal value, clearing the running count and writing the control word with both the enable and the run bits set. The count climbs by one per clock. When the count reaches the terminal value while the timer is enabled, the timer fires once. It drops its enable bit and raises an interrupt line for each thread that is subscribed at that moment.

Each thread acknowledges its interrupt by clearing its mask bit and rewriting the control word. It sets the enable bit again only if some other thread is still subscribed, so the timer stays idle once nobody is listening. A debug-halt input and a run bit in the control word can each freeze the count. Registers are accessed through a simple single-cycle write port and a combinational read port selected by a 2-bit address.

Top module: `mt_event_timer`

## Requirements
- R1: After reset, all four registers read as zero and every interrupt line is low.
- R2: Address 0 selects the subscriber mask (low NUM_THREADS bits; upper bits read zero). Address 1 selects the terminal value, address 2 the control word and address 3 the running count. A read returns the current register value in the same cycle, and a write takes effect at the next clock edge.
- R3: The control word has the enable flag in bit 0 and the run flag in bit 1; its other bits read zero. While run is 1 and the debug-halt input is low, the count rises by one per clock. It stops and holds once it equals the terminal value, and it never wraps.
- R4: While run is 0 or the debug-halt input is 1, the count does not change unless it is written.
- R5: A count write in a cycle where the count would also advance loads the written value.
- R6: When enable is 1 and the count equals the terminal value, the next edge clears enable and raises irq[n] for every bit n set in the mask. A mask write in that same cycle provides the mask value that is used.
- R7: After firing, no interrupt line rises again until the control word is written with enable set.
- R8: irq[n] stays high until mask bit n is cleared or the control word is written. A control write in the cycle of a match takes priority, so the timer does not fire and the enable bit takes the written value.
- R9: irq[n] is never high while mask bit n is 0. A mask bit that is set after the timer has fired does not raise its line.
- R10: Writing control with enable set while the count already equals the terminal value re-arms the timer, and it fires one cycle later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_we | input | 1 | Write strobe for the addressed register |
| reg_addr | input | 2 | Register select: 0 mask, 1 terminal, 2 control, 3 count |
| reg_wdata | input | CNT_W | Write data |
| reg_rdata | output | CNT_W | Read data of the addressed register |
| dbg_halt | input | 1 | Freezes the count while high |
| irq | output | NUM_THREADS | One interrupt line per hardware thread |

## Verification
The bench builds the block with NUM_THREADS = 8 and CNT_W = 8. With an 8-bit count, saturation at the terminal value, terminal values of 0 and 255, and repeated fire and acknowledge rounds all fit within a short run. Random terminal values are mostly kept below 16, so the random phase passes through many expiries. In these expiries, control writes, mask edits and halts land on the match cycle and the cycles around it. Eight threads keep the mask as wide as the data bus, which tests the boundary case where the mask has no zero-filled upper bits.

// File: rtl/mtet_pkg.sv
package mtet_pkg;
   typedef enum logic [1:0] {
      SEL_MASK  = 2'd0,
      SEL_LIMIT = 2'd1,
      SEL_CTRL  = 2'd2,
      SEL_COUNT = 2'd3
   } mtet_sel_e;

   localparam int CTRL_EN_BIT  = 0;
   localparam int CTRL_RUN_BIT = 1;
endpackage

// File: rtl/mtet_counter.sv
module mtet_counter #(
   parameter int CNT_W = 32
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             cnt_wr,
   input  logic             lim_wr,
   input  logic [CNT_W-1:0] wdata,
   input  logic             run,
   input  logic             dbg_halt,
   output logic [CNT_W-1:0] count,
   output logic [CNT_W-1:0] limit,
   output logic             at_limit
);
   logic advance;

   assign at_limit = (count == limit);
   assign advance  = run && !dbg_halt && !at_limit;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         count <= '0;
         limit <= '0;
      end else begin
         if (lim_wr) limit <= wdata;
         if (cnt_wr)       count <= wdata;
         else if (advance) count <= count + CNT_W'(1);
      end
   end

   // R4: frozen when halted or not running
   a_r4_frozen_when_halted: assert property (@(posedge clk) disable iff (!rst_n)
      (!cnt_wr && (!run || dbg_halt)) |=> $stable(count));
   // R3: no wrap once at terminal value
   a_r3_hold_at_limit: assert property (@(posedge clk) disable iff (!rst_n)
      (!cnt_wr && !lim_wr && at_limit) |=> (count == $past(count)));
   // R5: a write wins over an increment
   a_r5_write_priority: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_wr |=> (count == $past(wdata)));
endmodule

// File: rtl/mtet_arm.sv
module mtet_arm
   import mtet_pkg::*;
#(
   parameter int CNT_W = 32
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             ctrl_wr,
   input  logic [CNT_W-1:0] wdata,
   input  logic             at_limit,
   output logic             en,
   output logic             run,
   output logic             fire
);
   // a control write in the match cycle suppresses the expiry
   assign fire = en && at_limit && !ctrl_wr;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         en  <= 1'b0;
         run <= 1'b0;
      end else if (ctrl_wr) begin
         en  <= wdata[CTRL_EN_BIT];
         run <= wdata[CTRL_RUN_BIT];
      end else if (fire) begin
         en  <= 1'b0;
      end
   end

   // R6 / R7: firing disarms the timer
   a_r6_fire_disarms: assert property (@(posedge clk) disable iff (!rst_n)
      fire |=> !en);
   // R7: enable only rises through a control write
   a_r7_rearm_by_write: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(en) |-> $past(ctrl_wr));
endmodule

// File: rtl/mtet_fanout.sv
module mtet_fanout #(
   parameter int NUM_THREADS = 16
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   mask_wr,
   input  logic [NUM_THREADS-1:0] mask_wdata,
   input  logic                   ctrl_wr,
   input  logic                   fire,
   output logic [NUM_THREADS-1:0] mask,
   output logic [NUM_THREADS-1:0] irq
);
   logic [NUM_THREADS-1:0] mask_nx;

   assign mask_nx = mask_wr ? mask_wdata : mask;

   always_ff @(posedge clk) begin
      if (!rst_n) mask <= '0;
      else        mask <= mask_nx;
   end

   for (genvar t = 0; t < NUM_THREADS; t++) begin : g_thr
      always_ff @(posedge clk) begin
         if (!rst_n || ctrl_wr) irq[t] <= 1'b0;
         else if (fire)         irq[t] <= mask_nx[t];
         else                   irq[t] <= irq[t] && mask_nx[t];
      end
   end

   // R9: no line without its subscription
   a_r9_irq_in_mask: assert property (@(posedge clk) disable iff (!rst_n)
      ((irq & ~mask) == '0));
   // R8: a control write drops every line
   a_r8_ctrl_clears: assert property (@(posedge clk) disable iff (!rst_n)
      ctrl_wr |=> (irq == '0));
endmodule

// File: rtl/mt_event_timer.sv
module mt_event_timer
   import mtet_pkg::*;
#(
   parameter int NUM_THREADS = 16,
   parameter int CNT_W       = 32
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   reg_we,
   input  logic [1:0]             reg_addr,
   input  logic [CNT_W-1:0]       reg_wdata,
   output logic [CNT_W-1:0]       reg_rdata,
   input  logic                   dbg_halt,
   output logic [NUM_THREADS-1:0] irq
);
   if (NUM_THREADS < 1 || NUM_THREADS > CNT_W) begin : g_bad_threads
      $error("NUM_THREADS must be between 1 and CNT_W");
   end
   if (CNT_W < 2) begin : g_bad_width
      $error("CNT_W must be at least 2");
   end

   logic                   wr_mask, wr_lim, wr_ctrl, wr_cnt;
   logic [CNT_W-1:0]       count, limit;
   logic [NUM_THREADS-1:0] mask;
   logic                   at_limit, en, run, fire;
   logic [CNT_W-1:0]       mask_ext, ctrl_ext;

   assign wr_mask = reg_we && (reg_addr == SEL_MASK);
   assign wr_lim  = reg_we && (reg_addr == SEL_LIMIT);
   assign wr_ctrl = reg_we && (reg_addr == SEL_CTRL);
   assign wr_cnt  = reg_we && (reg_addr == SEL_COUNT);

   mtet_counter #(.CNT_W(CNT_W)) u_cnt (
      .clk(clk), .rst_n(rst_n), .cnt_wr(wr_cnt), .lim_wr(wr_lim),
      .wdata(reg_wdata), .run(run), .dbg_halt(dbg_halt),
      .count(count), .limit(limit), .at_limit(at_limit)
   );

   mtet_arm #(.CNT_W(CNT_W)) u_arm (
      .clk(clk), .rst_n(rst_n), .ctrl_wr(wr_ctrl), .wdata(reg_wdata),
      .at_limit(at_limit), .en(en), .run(run), .fire(fire)
   );

   mtet_fanout #(.NUM_THREADS(NUM_THREADS)) u_fan (
      .clk(clk), .rst_n(rst_n), .mask_wr(wr_mask),
      .mask_wdata(reg_wdata[NUM_THREADS-1:0]), .ctrl_wr(wr_ctrl),
      .fire(fire), .mask(mask), .irq(irq)
   );

   always_comb begin
      mask_ext = '0;
      mask_ext[NUM_THREADS-1:0] = mask;
      ctrl_ext = '0;
      ctrl_ext[CTRL_EN_BIT]  = en;
      ctrl_ext[CTRL_RUN_BIT] = run;
      unique case (reg_addr)
         SEL_MASK:  reg_rdata = mask_ext;
         SEL_LIMIT: reg_rdata = limit;
         SEL_CTRL:  reg_rdata = ctrl_ext;
         default:   reg_rdata = count;
      endcase
   end

   // R6: a line only rises on the edge after an expiry
   a_r6_rise_after_fire: assert property (@(posedge clk) disable iff (!rst_n)
      ((irq & ~$past(irq)) != '0) |-> $past(fire));
endmodule

// File: tb/sim_mt_event_timer.sv
`timescale 1ns/1ps
module sim_mt_event_timer;
   localparam int NT = 8;
   localparam int CW = 8;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          reg_we = 1'b0;
   logic [1:0]    reg_addr = 2'd0;
   logic [CW-1:0] reg_wdata = '0;
   logic          dbg_halt = 1'b0;
   logic [CW-1:0] reg_rdata;
   logic [NT-1:0] irq;

   int n_chk = 0;
   int n_fail = 0;
   bit done = 1'b0;

   // reference state
   logic [NT-1:0] m_mask = '0, m_pend = '0;
   logic [CW-1:0] m_lim = '0, m_cnt = '0;
   logic          m_en = 1'b0, m_run = 1'b0;

   always #2.5 clk = ~clk;

   mt_event_timer #(.NUM_THREADS(NT), .CNT_W(CW)) u0 (
      .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .dbg_halt(dbg_halt),
      .irq(irq)
   );

   function automatic logic [CW-1:0] exp_read(input logic [1:0] a);
      logic [CW-1:0] v;
      v = '0;
      case (a)
         2'd0: v[NT-1:0] = m_mask;
         2'd1: v = m_lim;
         2'd2: begin v[0] = m_en; v[1] = m_run; end
         default: v = m_cnt;
      endcase
      return v;
   endfunction

   task automatic check(input string tag, input string what,
                        input logic [CW-1:0] act, input logic [CW-1:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
      end
   endtask

   task automatic step(input logic we, input logic [1:0] a,
                       input logic [CW-1:0] d, input logic h, input string tag);
      logic          fire, cw;
      logic [NT-1:0] mnx;
      @(negedge clk);
      reg_we = we; reg_addr = a; reg_wdata = d; dbg_halt = h;
      cw   = we && a == 2'd2;
      fire = m_en && (m_cnt == m_lim) && !cw;
      mnx  = (we && a == 2'd0) ? d[NT-1:0] : m_mask;
      @(posedge clk);
      #1;
      if (cw) m_pend = '0;
      else if (fire) m_pend = mnx;
      else m_pend = m_pend & mnx;
      if (we && a == 2'd3) m_cnt = d;
      else if (m_run && !h && m_cnt != m_lim) m_cnt = m_cnt + 1'b1;
      if (we && a == 2'd1) m_lim = d;
      if (cw) begin m_en = d[0]; m_run = d[1]; end
      else if (fire) m_en = 1'b0;
      m_mask = mnx;
      check(tag, "irq", CW'(irq), CW'(m_pend));
      check(tag, "rdata", reg_rdata, exp_read(a));
   endtask

   task automatic idle(input int n, input logic h, input string tag);
      for (int i = 0; i < n; i++) step(1'b0, 2'd3, '0, h, tag);
   endtask

   initial begin
      #(5.0 * 190000);
      if (!done) begin
         n_chk++; n_fail++;
         $display("FAIL watchdog: actual hung expected finished");
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'd1234));
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      // R1: reset state
      for (int a = 0; a < 4; a++) step(1'b0, 2'(a), '0, 1'b0, "R1");
      // R2: map and readback
      step(1'b1, 2'd0, 8'h05, 1'b0, "R2");
      step(1'b1, 2'd1, 8'd5, 1'b0, "R2");
      step(1'b1, 2'd3, 8'd0, 1'b0, "R2");
      step(1'b0, 2'd0, '0, 1'b0, "R2");
      // R3 / R6: arm and count up to expiry
      step(1'b1, 2'd2, 8'h03, 1'b0, "R6");
      idle(4, 1'b0, "R3");
      idle(4, 1'b0, "R6");
      // R9: subscribing after expiry raises nothing new
      step(1'b1, 2'd0, 8'h07, 1'b0, "R9");
      // R8: thread 0 drops out, then control write clears the rest
      step(1'b1, 2'd0, 8'h06, 1'b0, "R8");
      step(1'b0, 2'd2, '0, 1'b0, "R8");
      step(1'b1, 2'd2, 8'h02, 1'b0, "R8");
      // R7: one-shot, counter saturated, nothing fires
      idle(6, 1'b0, "R7");
      // R10: re-arm with count at limit fires one cycle later
      step(1'b1, 2'd2, 8'h03, 1'b0, "R10");
      step(1'b0, 2'd2, '0, 1'b0, "R10");
      step(1'b1, 2'd2, 8'h02, 1'b0, "R10");
      // R4: freeze by debug halt and by run flag
      step(1'b1, 2'd1, 8'd200, 1'b0, "R4");
      step(1'b1, 2'd3, 8'd0, 1'b0, "R4");
      idle(3, 1'b0, "R3");
      idle(5, 1'b1, "R4");
      step(1'b1, 2'd2, 8'h00, 1'b0, "R4");
      idle(5, 1'b0, "R4");
      // R5: write while running
      step(1'b1, 2'd2, 8'h02, 1'b0, "R5");
      step(1'b1, 2'd3, 8'd100, 1'b0, "R5");
      step(1'b1, 2'd3, 8'd50, 1'b0, "R5");
      // R3: top of range, no wrap
      step(1'b1, 2'd1, 8'hFF, 1'b0, "R3");
      step(1'b1, 2'd3, 8'hFD, 1'b0, "R3");
      idle(5, 1'b0, "R3");
      // R8: control write in the match cycle wins, terminal value 0
      step(1'b1, 2'd0, 8'hFF, 1'b0, "R8");
      step(1'b1, 2'd1, 8'd0, 1'b0, "R8");
      step(1'b1, 2'd3, 8'd0, 1'b0, "R8");
      step(1'b1, 2'd2, 8'h03, 1'b0, "R8");
      step(1'b1, 2'd2, 8'h03, 1'b0, "R8");
      step(1'b0, 2'd2, '0, 1'b0, "R6");
      // R6: mask write in the expiry cycle supplies the mask
      step(1'b1, 2'd2, 8'h03, 1'b0, "R6");
      step(1'b1, 2'd0, 8'h81, 1'b0, "R6");
      // random phase
      for (int i = 0; i < 6000; i++) begin
         logic          we, h;
         logic [1:0]    a;
         logic [CW-1:0] d;
         we = ($urandom % 100) < 25;
         h  = ($urandom % 100) < 8;
         a  = 2'($urandom % 4);
         d  = 8'($urandom);
         if (a == 2'd1 || a == 2'd3) begin
            if (($urandom % 8) != 0) d = d % 16;
         end
         if (a == 2'd2 && ($urandom % 4) != 0) d = 8'h03;
         step(we, a, d, h, "R7");
      end
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end
endmodule